// File: doc/BRIEF.md
# Decimal-Fraction Sample Attenuator

This block scales a stream of signed 16-bit samples by a decimal fraction between 0.000 and 0.999. The fraction arrives from a controller as three packed BCD digits on a 12-bit word. A rising edge on the load strobe captures the word into a setting register. Driving the active-low clear input empties that register, which sets the gain to zero.

The strobe and the clear are synchronised to the block clock. The stored digits are turned into a binary count N (0 to 999) by a registered conversion stage. Each accepted sample is multiplied by N and divided by 1000 with rounding, in a two-stage pipeline with valid/ready handshaking on both sides.

A capture whose word holds a digit above nine is refused. The setting keeps its previous value and a sticky error flag is raised.

Top module: `bcd_gain_scaler`

## Requirements
- R1: The digits are packed as bits [11:8] = tenths (most significant), [7:4] = hundredths and [3:0] = thousandths. The gain is N/1000 with N = 100*[11:8] + 10*[7:4] + [3:0].
- R2: The output sample equals sample*N/1000, rounded to the nearest integer, with exact halves rounded away from zero.
- R3: The setting changes only after a low-to-high transition of `load_strobe`. Changing `bcd_word` while the strobe is steady, or while it is held high, has no effect on the gain.
- R4: While `clear_n` is low, the setting is forced to zero. Clear wins over a strobe edge that arrives at the same time.
- R5: A stored setting of 0x000 gives an output of exactly zero for every input sample.
- R6: A stored setting of 0x999 gives 0.999 times the input, rounded as in R2, including at both full-scale input extremes.
- R7: The strobe and the clear each pass through a two-flop synchroniser. A captured word takes effect for samples accepted eight or more cycles after the strobe rises.
- R8: A capture in which any digit exceeds 9 leaves the setting unchanged and sets `bcd_err`. `bcd_err` stays set until reset.
- R9: `in_ready` equals `out_ready` OR NOT `out_valid`. When `out_ready` is high, a sample accepted at one rising edge shows on `out_valid`/`out_sample` after the next rising edge.
- R10: While `out_valid` is high and `out_ready` is low, `out_sample` holds its value and `out_valid` stays high.
- R11: After reset, `out_valid` and `bcd_err` are low and the gain is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bcd_word | input | 12 | Three BCD digits of the gain fraction |
| load_strobe | input | 1 | Capture on rising edge (asynchronous) |
| clear_n | input | 1 | Active-low clear of the setting (asynchronous) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high with in_valid |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream ready |
| out_sample | output | 16 | Signed scaled sample |
| bcd_err | output | 1 | Sticky invalid-digit flag |

## Verification
The hardest case to reach from the ports is a clear that lands in the same synchronised cycle as a strobe edge. Both signals cross the same two-flop depth, so the bench changes them at the same falling edge. It then releases the clear while the strobe is still held high. A block that let the strobe win, or that treated a steady high strobe as a new edge, would show a non-zero product. Rounding is probed at exact halves of both signs and at the two full-scale inputs.

// File: rtl/bcd_gain_pkg.sv
package bcd_gain_pkg;
  localparam int DIGIT_W = 4;
  localparam int MAX_DIGIT = 9;

  function automatic logic digit_ok(input logic [DIGIT_W-1:0] d);
    return d <= DIGIT_W'(MAX_DIGIT);
  endfunction
endpackage

// File: rtl/bcd_setting_reg.sv
module bcd_setting_reg
  import bcd_gain_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = DIGITS * DIGIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] bcd_i,
  input  logic              strobe_i,
  input  logic              clear_n_i,
  output logic [WORD_W-1:0] setting_o,
  output logic              cap_en_o,
  output logic              clr_act_o,
  output logic              err_o
);
  logic [SYNC_STAGES:0]   stb_q;
  logic [SYNC_STAGES-1:0] clr_q;
  logic                   pend_q, pend_d;
  logic [WORD_W-1:0]      set_q, set_d;
  logic                   err_q, err_d;
  logic                   rise;
  logic [DIGITS-1:0]      dig_ok;
  logic                   all_ok;

  // synchronisers; the extra strobe stage gives the previous value for edge detect
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= '0;
      clr_q <= '0;
    end else begin
      stb_q <= {stb_q[SYNC_STAGES-1:0], strobe_i};
      clr_q <= {clr_q[SYNC_STAGES-2:0], clear_n_i};
    end
  end

  assign rise      = stb_q[SYNC_STAGES-1] & ~stb_q[SYNC_STAGES];
  assign clr_act_o = ~clr_q[SYNC_STAGES-1];
  assign cap_en_o  = pend_q & ~clr_act_o;

  for (genvar g = 0; g < DIGITS; g++) begin : g_chk
    assign dig_ok[g] = digit_ok(bcd_i[g*DIGIT_W +: DIGIT_W]);
  end
  assign all_ok = &dig_ok;

  always_comb begin
    pend_d = rise & ~clr_act_o;
    set_d  = set_q;
    err_d  = err_q;
    if (clr_act_o) begin
      set_d = '0;
    end else if (cap_en_o) begin
      if (all_ok) set_d = bcd_i;
      else        err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      set_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      set_q  <= set_d;
      err_q  <= err_d;
    end
  end

  assign setting_o = set_q;
  assign err_o     = err_q;
endmodule

// File: rtl/bcd_to_count.sv
module bcd_to_count
  import bcd_gain_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int N_W = 10,
  localparam int WORD_W = DIGITS * DIGIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] setting_i,
  output logic [N_W-1:0]    n_o
);
  logic [N_W-1:0] n_d, n_q;

  // Horner form: the most significant digit sits at the top of the word
  always_comb begin
    n_d = '0;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      n_d = N_W'(n_d * N_W'(10)) + N_W'(setting_i[i*DIGIT_W +: DIGIT_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) n_q <= '0;
    else        n_q <= n_d;
  end

  assign n_o = n_q;
endmodule

// File: rtl/frac_mult_pipe.sv
module frac_mult_pipe #(
  parameter int SAMPLE_W = 16,
  parameter int N_W = 10,
  parameter int SCALE = 1000,
  localparam int PROD_W = SAMPLE_W + N_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic [N_W-1:0]      n_i,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample
);
  logic                       adv;
  logic                       v1_q, v1_d, v2_q, v2_d;
  logic signed [PROD_W-1:0]   s_ext, n_ext, prod_d, prod_q;
  logic        [PROD_W-1:0]   mag, quo;
  logic signed [PROD_W-1:0]   res;
  logic [SAMPLE_W-1:0]        out_d, out_q;
  logic                       en1, en2;

  assign adv      = out_ready | ~v2_q;
  assign in_ready = adv;
  assign en1      = adv & in_valid;
  assign en2      = adv & v1_q;

  always_comb begin
    s_ext  = {{(PROD_W-SAMPLE_W){in_sample[SAMPLE_W-1]}}, in_sample};
    n_ext  = {{(PROD_W-N_W){1'b0}}, n_i};
    prod_d = s_ext * n_ext;
    v1_d   = adv ? in_valid : v1_q;
    v2_d   = adv ? v1_q : v2_q;
  end

  // round half away from zero on the magnitude
  always_comb begin
    mag   = prod_q[PROD_W-1] ? PROD_W'(-prod_q) : PROD_W'(prod_q);
    quo   = (mag + PROD_W'(SCALE / 2)) / PROD_W'(SCALE);
    res   = prod_q[PROD_W-1] ? -$signed(quo) : $signed(quo);
    out_d = res[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      v2_q   <= 1'b0;
      prod_q <= '0;
      out_q  <= '0;
    end else begin
      v1_q <= v1_d;
      v2_q <= v2_d;
      if (en1) prod_q <= prod_d;
      if (en2) out_q  <= out_d;
    end
  end

  assign out_valid  = v2_q;
  assign out_sample = out_q;
endmodule

// File: rtl/bcd_gain_scaler.sv
module bcd_gain_scaler
  import bcd_gain_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int SAMPLE_W = 16,
  localparam int WORD_W = DIGITS * DIGIT_W,
  localparam int N_W = 10,
  localparam int SCALE = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   bcd_word,
  input  logic                load_strobe,
  input  logic                clear_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_sample,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_sample,
  output logic                bcd_err
);
  logic [WORD_W-1:0] setting;
  logic              cap_en;
  logic              clr_act;
  logic [N_W-1:0]    n_val;

  bcd_setting_reg #(.DIGITS(DIGITS), .SYNC_STAGES(2)) u_set (
    .clk(clk), .rst_n(rst_n), .bcd_i(bcd_word), .strobe_i(load_strobe),
    .clear_n_i(clear_n), .setting_o(setting), .cap_en_o(cap_en),
    .clr_act_o(clr_act), .err_o(bcd_err)
  );

  bcd_to_count #(.DIGITS(DIGITS), .N_W(N_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .setting_i(setting), .n_o(n_val)
  );

  frac_mult_pipe #(.SAMPLE_W(SAMPLE_W), .N_W(N_W), .SCALE(SCALE)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .n_i(n_val), .out_valid(out_valid),
    .out_ready(out_ready), .out_sample(out_sample)
  );
endmodule

// File: rtl/bcd_gain_scaler_chk.sv
module bcd_gain_scaler_chk #(
  parameter int WORD_W = 12,
  parameter int N_W = 10,
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [WORD_W-1:0]   bcd_word,
  input logic [WORD_W-1:0]   setting,
  input logic                cap_en,
  input logic                clr_act,
  input logic                bcd_err,
  input logic [N_W-1:0]      n_val,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [SAMPLE_W-1:0] out_sample
);
  logic bad;
  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < WORD_W / 4; i++) begin
      if (bcd_word[i*4 +: 4] > 4'd9) bad = 1'b1;
    end
  end

  p_n_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    n_val <= N_W'(999));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !clr_act) |=> $stable(setting));
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_act |=> (setting == '0));
  p_bad_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !clr_act && bad) |=> ($stable(setting) && bcd_err));
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bcd_err |=> bcd_err);
  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sample)));
endmodule

bind bcd_gain_scaler bcd_gain_scaler_chk #(.WORD_W(WORD_W), .N_W(N_W), .SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bcd_word(bcd_word), .setting(setting),
  .cap_en(cap_en), .clr_act(clr_act), .bcd_err(bcd_err), .n_val(n_val),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .out_sample(out_sample)
);

// File: tb/bcd_gain_scaler_bench.sv
`timescale 1ns/1ps
module bcd_gain_scaler_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bcd_word;
  logic        load_strobe, clear_n, in_valid, out_ready;
  logic [15:0] in_sample;
  logic        in_ready, out_valid, bcd_err;
  logic [15:0] out_sample;

  int checks = 0;
  int fails = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  bcd_gain_scaler u_bcd_gain_scaler (
    .clk(clk), .rst_n(rst_n), .bcd_word(bcd_word), .load_strobe(load_strobe),
    .clear_n(clear_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_ready(out_ready),
    .out_sample(out_sample), .bcd_err(bcd_err)
  );

  // {bcd setting, input sample, expected output}
  localparam int NV = 10;
  localparam logic [43:0] VEC [NV] = '{
    {12'h999, 16'h03E8, 16'h03E7},  // R6: 1000 -> 999
    {12'h999, 16'h7FFF, 16'h7FDE},  // R6: 32767 -> 32734
    {12'h999, 16'h8000, 16'h8021},  // R6: -32768 -> -32735
    {12'h500, 16'h0003, 16'h0002},  // R2: 1.5 -> 2
    {12'h500, 16'hFFFD, 16'hFFFE},  // R2: -1.5 -> -2
    {12'h000, 16'h3039, 16'h0000},  // R5: zero gain
    {12'h123, 16'h03E8, 16'h007B},  // R1: digit weights
    {12'h001, 16'h01F3, 16'h0000},  // R2: 0.499 -> 0
    {12'h001, 16'h01F4, 16'h0001},  // R2: 0.5 -> 1
    {12'h250, 16'hFFF9, 16'hFFFE}   // R1: -1.75 -> -2
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_gain(input logic [11:0] w);
    @(negedge clk);
    bcd_word = w;
    load_strobe = 1'b1;
    repeat (8) @(negedge clk);
    load_strobe = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input string req, input logic [15:0] s, input logic [15:0] exp);
    @(negedge clk);
    in_valid = 1'b1;
    in_sample = s;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R9 early"}, {15'd0, out_valid}, 16'd0);
    @(negedge clk);
    check({req, " R9 valid"}, {15'd0, out_valid}, 16'd1);
    check(req, out_sample, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    bcd_word = 12'h000;
    load_strobe = 1'b0;
    clear_n = 1'b1;
    in_valid = 1'b0;
    in_sample = '0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check("R11 out_valid", {15'd0, out_valid}, 16'd0);
    check("R11 bcd_err", {15'd0, bcd_err}, 16'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send("R11 zero gain", 16'h1234, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      set_gain(VEC[i][43:32]);
      send("R1/R2 table", VEC[i][31:16], VEC[i][15:0]);
    end

    // R3: word changes without a strobe edge
    set_gain(12'h500);
    @(negedge clk);
    bcd_word = 12'h999;
    repeat (10) @(negedge clk);
    send("R3 no strobe", 16'h03E8, 16'h01F4);
    // R3: strobe held high, word changes later
    @(negedge clk);
    bcd_word = 12'h250;
    load_strobe = 1'b1;
    repeat (10) @(negedge clk);
    bcd_word = 12'h999;
    repeat (10) @(negedge clk);
    send("R3 held strobe", 16'h03E8, 16'h00FA);
    load_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R4: plain clear
    set_gain(12'h999);
    @(negedge clk);
    clear_n = 1'b0;
    repeat (4) @(negedge clk);
    clear_n = 1'b1;
    repeat (6) @(negedge clk);
    send("R4 clear", 16'h03E8, 16'h0000);

    // R4/R7: clear and strobe rise together, clear released first
    @(negedge clk);
    bcd_word = 12'h999;
    load_strobe = 1'b1;
    clear_n = 1'b0;
    repeat (6) @(negedge clk);
    clear_n = 1'b1;
    repeat (8) @(negedge clk);
    send("R4 clear priority", 16'h03E8, 16'h0000);
    load_strobe = 1'b0;
    repeat (3) @(negedge clk);

    // R7: new gain applies eight cycles after strobe
    @(negedge clk);
    bcd_word = 12'h100;
    load_strobe = 1'b1;
    repeat (7) @(negedge clk);
    send("R7 capture delay", 16'h03E8, 16'h0064);
    load_strobe = 1'b0;

    // R8: invalid digit keeps setting, raises sticky error
    set_gain(12'h123);
    check("R8 err before", {15'd0, bcd_err}, 16'd0);
    set_gain(12'h9A0);
    check("R8 err set", {15'd0, bcd_err}, 16'd1);
    send("R8 setting kept", 16'h03E8, 16'h007B);
    set_gain(12'h200);
    check("R8 err sticky", {15'd0, bcd_err}, 16'd1);

    // R10: backpressure
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_sample = 16'h03E8;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 valid held", {15'd0, out_valid}, 16'd1);
    check("R10 data held", out_sample, 16'h00C8);
    check("R9 ready low", {15'd0, in_ready}, 16'd0);
    out_ready = 1'b1;
    @(negedge clk);
    check("R9 drained", {15'd0, out_valid}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule